// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter Node

This block is the arbitration logic for one node in a cluster of up to six processors that share one external bus. No central arbiter exists. Every node holds its own copy of the bus ownership state, watches the same shared request, host and core-priority lines, and therefore reaches the same decision on the same clock edge. A node asserts only the request line that its hardwired ID selects. When the current owner drops its request, ownership passes to the winning requester. Winners are chosen by fixed priority, where the lowest ID wins, or by rotating priority, where the search starts just after the releasing owner. A runtime select input picks between the two modes.

An external host can take the bus away from every processor. The owning node finishes its current transfer cycle and spends one cycle with its bus outputs off. It then pulls the shared host-grant line low and holds it there until the host withdraws its request. While the host request or the grant is active, ownership is frozen on every node. A slave whose core needs the bus can pull a shared core-priority line low. Nodes that want the bus only for background DMA then withhold their requests, so the core requester wins the next arbitration. With ID 0 the node works as a lone processor: it always owns the bus and never requests.

Top module: `mpa_node`

## Requirements
- R1: A node with ID k (1..6) drives low only bit k-1 of `req_n_out`, and only while it requests; all other bits stay high.
- R2: With ID 0 the node is always master and keeps every bit of `req_n_out` high, whatever `want_bus` does.
- R3: In fixed mode (`rot_sel`=0), on the edge after the owner's request line goes high, the lowest-numbered asserted request line becomes owner.
- R4: In rotating mode (`rot_sel`=1), the winner is the first asserted request line found searching upward from the releasing owner's number, wrapping from 6 to 1.
- R5: The owner keeps the bus while its own request line is low, even if higher-priority requests appear. Ownership moves in a single edge, so at most one node has `bus_en` high in any cycle.
- R6: After reset, node 1 owns the bus with `bus_en` high, every other node has `bus_en` low, and `hbg_n_out` and `cpa_n_out` are high.
- R7: On a host request (`host_req_n` low) the owner keeps `bus_en` while `xfer_busy` is high. On the first edge with `xfer_busy` low it drops `bus_en`, and one edge later it drives `hbg_n_out` low.
- R8: `hbg_n_out` stays low until `host_req_n` is sampled high. The owner then raises it and restores `bus_en` on that edge. Ownership never changes while `host_req_n` or `hbg_n_in` is low.
- R9: A non-owning node with `core_prio` and `want_bus` high drives `cpa_n_out` low. While `cpa_n_in` is low, any node with `dma_xfer` high and `core_prio` low withholds its request, unless it is the owner and `xfer_busy` is high.
- R10: A change of `rot_sel` applies to the very next arbitration edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 3 | Hardwired node ID, 0 = single processor |
| rot_sel | input | 1 | 1 = rotating priority, 0 = fixed priority |
| want_bus | input | 1 | Local core or DMA wants the bus |
| xfer_busy | input | 1 | Owner is inside a transfer cycle that must complete |
| dma_xfer | input | 1 | Local bus demand is background DMA only |
| core_prio | input | 1 | Local core needs priority access |
| req_n_in | input | 6 | Observed shared request lines, active low |
| req_n_out | output | 6 | Request line drive, active low, only the own bit may be low |
| cpa_n_in | input | 1 | Observed shared core-priority line, active low |
| cpa_n_out | output | 1 | Core-priority drive, active low |
| host_req_n | input | 1 | Host bus request, active low |
| hbg_n_in | input | 1 | Observed shared host grant line, active low |
| hbg_n_out | output | 1 | Host grant drive, active low |
| is_master | output | 1 | Node currently owns the bus |
| bus_en | output | 1 | Bus outputs enabled, low means tri-stated |

## Verification
The assertions check on every cycle that at most one request bit is driven, that an ID-0 node stays silent and master, and that an owner holding its request keeps the bus. They also check that ownership is frozen during any host activity, that the grant follows a release cycle and is held while the host requests, and that the bus is off under grant. Only the six-node bench can show that the replicated ownership state agrees across nodes, with exactly one bus enable in each cycle. The bench alone also shows that fixed and rotating modes pick the right winner, that a mode change applies at once, and that the core-priority line actually steers the winner away from DMA-only requesters.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [1:0] {
    HS_NORM  = 2'd0,
    HS_REL   = 2'd1,
    HS_GRANT = 2'd2
  } hs_state_t;
endpackage

// File: rtl/mpa_prio_pick.sv
module mpa_prio_pick #(
  parameter int N_NODES = 6,
  parameter int IW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_NODES-1:0] req_act,
  input  logic [IW-1:0]      last,
  input  logic               rot_sel,
  output logic               found,
  output logic [IW-1:0]      win
);
  logic          fx_found, rt_found;
  logic [IW-1:0] fx_win, rt_win;

  // fixed priority: lowest index wins
  always_comb begin
    fx_found = 1'b0;
    fx_win   = '0;
    for (int i = N_NODES - 1; i >= 0; i--) begin
      if (req_act[i]) begin
        fx_found = 1'b1;
        fx_win   = IW'(i + 1);
      end
    end
  end

  // rotating priority: search upward from the releasing owner
  always_comb begin
    rt_found = 1'b0;
    rt_win   = '0;
    for (int k = N_NODES; k >= 1; k--) begin
      int idx;
      idx = (int'(last) - 1 + k) % N_NODES;
      if (req_act[idx]) begin
        rt_found = 1'b1;
        rt_win   = IW'(idx + 1);
      end
    end
  end

  assign found = rot_sel ? rt_found : fx_found;
  assign win   = rot_sel ? rt_win   : fx_win;

  assert_win_requests_R3: assert property (@(posedge clk) disable iff (rst)
    found |-> (win != '0 && req_act[win - 1'b1]))
    else $error("winner is not an active requester");
endmodule

// File: rtl/mpa_host_hs.sv
module mpa_host_hs
  import mpa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      own,
  input  logic      busy,
  input  logic      host_req_n,
  output hs_state_t st,
  output logic      hbg_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HS_NORM;
      hbg_n <= 1'b1;
    end else begin
      unique case (st)
        HS_NORM:  if (own && !host_req_n && !busy) st <= HS_REL;
        HS_REL: begin
          st    <= HS_GRANT;
          hbg_n <= 1'b0;
        end
        HS_GRANT: if (host_req_n) begin
          st    <= HS_NORM;
          hbg_n <= 1'b1;
        end
        default:  st <= HS_NORM;
      endcase
    end
  end

  assert_grant_after_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(hbg_n) |-> ($past(st) == HS_REL))
    else $error("grant without release cycle");

  assert_grant_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!hbg_n && !host_req_n) |=> !hbg_n)
    else $error("grant dropped while host requests");
endmodule

// File: rtl/mpa_node.sv
module mpa_node
  import mpa_pkg::*;
#(
  parameter int N_NODES = 6,
  parameter int IW      = $clog2(N_NODES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IW-1:0]      node_id,
  input  logic               rot_sel,
  input  logic               want_bus,
  input  logic               xfer_busy,
  input  logic               dma_xfer,
  input  logic               core_prio,
  input  logic [N_NODES-1:0] req_n_in,
  output logic [N_NODES-1:0] req_n_out,
  input  logic               cpa_n_in,
  output logic               cpa_n_out,
  input  logic               host_req_n,
  input  logic               hbg_n_in,
  output logic               hbg_n_out,
  output logic               is_master,
  output logic               bus_en
);
  localparam logic [IW-1:0] DEFAULT_OWNER = IW'(1);

  logic          single;
  logic [IW-1:0] owner_q, owner_nx, pick_win;
  logic          own_q, req_q, cpa_q;
  logic          arb_en, pick_found, withhold;
  hs_state_t     hs_st;

  assign single   = (node_id == '0);
  assign arb_en   = host_req_n && hbg_n_in && !single && req_n_in[owner_q - 1'b1];
  assign withhold = !cpa_n_in && dma_xfer && !core_prio;
  assign owner_nx = (arb_en && pick_found) ? pick_win : owner_q;

  mpa_prio_pick #(.N_NODES(N_NODES), .IW(IW)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req_act (~req_n_in),
    .last    (owner_q),
    .rot_sel (rot_sel),
    .found   (pick_found),
    .win     (pick_win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= DEFAULT_OWNER;
      own_q   <= single || (node_id == DEFAULT_OWNER);
      req_q   <= 1'b0;
      cpa_q   <= 1'b0;
    end else begin
      owner_q <= owner_nx;
      own_q   <= single || (owner_nx == node_id);
      req_q   <= !single && ((want_bus && !withhold) || (own_q && xfer_busy));
      cpa_q   <= !single && core_prio && want_bus && !own_q;
    end
  end

  for (genvar i = 0; i < N_NODES; i++) begin : g_req
    assign req_n_out[i] = !(req_q && (node_id == IW'(i + 1)));
  end

  mpa_host_hs u_hs (
    .clk        (clk),
    .rst        (rst),
    .own        (own_q),
    .busy       (xfer_busy),
    .host_req_n (host_req_n),
    .st         (hs_st),
    .hbg_n      (hbg_n_out)
  );

  assign cpa_n_out = !cpa_q;
  assign is_master = own_q;
  assign bus_en    = own_q && (hs_st == HS_NORM);

  assert_one_line_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(~req_n_out) <= 1)
    else $error("more than one request line driven");

  assert_single_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (node_id == '0) |-> ((&req_n_out) && is_master))
    else $error("single node requested or lost mastership");

  assert_keep_while_req_R5: assert property (@(posedge clk) disable iff (rst)
    (is_master && !(&req_n_out) && !single) |=> is_master)
    else $error("owner lost bus while requesting");

  assert_freeze_host_R8: assert property (@(posedge clk) disable iff (rst)
    (!host_req_n || !hbg_n_in) |=> $stable(owner_q))
    else $error("ownership moved during host access");

  assert_off_under_grant_R7: assert property (@(posedge clk) disable iff (rst)
    !hbg_n_out |-> !bus_en)
    else $error("bus enabled while host granted");
endmodule

// File: tb/mpa_node_tb.sv
module mpa_node_tb;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         rot = 1'b0;
  logic         host_req_n = 1'b1;
  logic [N-1:0] want = '0, busy = '0, dma = '0, core = '0;
  logic [N-1:0] bus_en, is_m, cpa_o, hbg_o;
  logic [N-1:0] req_o [N];
  logic [N-1:0] req_line;
  logic         cpa_line, hbg_line;

  logic         s_want = 1'b0;
  logic [N-1:0] s_req;
  logic         s_cpa, s_hbg, s_master, s_en;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int m_owner = 1;
  bit chk_en = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_node
    mpa_node #(.N_NODES(N)) u_dut (
      .clk(clk), .rst(rst), .node_id(3'(i + 1)), .rot_sel(rot),
      .want_bus(want[i]), .xfer_busy(busy[i]), .dma_xfer(dma[i]),
      .core_prio(core[i]), .req_n_in(req_line), .req_n_out(req_o[i]),
      .cpa_n_in(cpa_line), .cpa_n_out(cpa_o[i]), .host_req_n(host_req_n),
      .hbg_n_in(hbg_line), .hbg_n_out(hbg_o[i]), .is_master(is_m[i]),
      .bus_en(bus_en[i]));
  end

  mpa_node #(.N_NODES(N)) u_single (
    .clk(clk), .rst(rst), .node_id(3'd0), .rot_sel(rot), .want_bus(s_want),
    .xfer_busy(1'b0), .dma_xfer(1'b0), .core_prio(1'b0), .req_n_in({N{1'b1}}),
    .req_n_out(s_req), .cpa_n_in(s_cpa), .cpa_n_out(s_cpa), .host_req_n(1'b1),
    .hbg_n_in(s_hbg), .hbg_n_out(s_hbg), .is_master(s_master), .bus_en(s_en));

  always_comb begin
    req_line = '1;
    for (int i = 0; i < N; i++) req_line &= req_o[i];
    cpa_line = &cpa_o;
    hbg_line = &hbg_o;
  end

  function automatic int pick(logic [N-1:0] act, int last, bit r);
    if (r) begin
      for (int k = 1; k <= N; k++)
        if (act[(last - 1 + k) % N]) return ((last - 1 + k) % N) + 1;
    end else begin
      for (int i = 0; i < N; i++) if (act[i]) return i + 1;
    end
    return 0;
  endfunction

  // reference ownership model built from the shared lines
  always @(posedge clk) begin
    if (rst) m_owner <= 1;
    else if (host_req_n && hbg_line && req_line[m_owner-1]) begin
      int w;
      w = pick(~req_line, m_owner, rot);
      if (w != 0) m_owner <= w;
    end
  end

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-cycle checks against the model
  always @(negedge clk) begin
    if (chk_en) begin
      chk($countones(bus_en) <= 1, "R5 one enable", 32'(bus_en), 32'(1 << (m_owner - 1)));
      chk(is_m == N'(1 << (m_owner - 1)), "R3/R4 owner model", 32'(is_m), 32'(1 << (m_owner - 1)));
      if (host_req_n && hbg_line)
        chk(bus_en == N'(1 << (m_owner - 1)), "R5 bus enable", 32'(bus_en), 32'(1 << (m_owner - 1)));
      chk(s_req == '1 && s_master, "R2 single node", 32'(s_req), 32'h3f);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24681));
    step(3);
    rst = 1'b0;
    step(1);
    chk(bus_en == 6'b000001, "R6 reset owner", 32'(bus_en), 32'h01);
    chk(hbg_line && cpa_line, "R6 reset lines", {hbg_line, cpa_line}, 2'b11);
    chk(s_en, "R2 single enabled", 32'(s_en), 1);
    chk_en = 1'b1;

    want = 6'b000100; s_want = 1'b1;
    step(1);
    chk(req_line == 6'b111011, "R1 own line", 32'(req_line), 32'h3b);
    chk(s_req == '1, "R2 no request", 32'(s_req), 32'h3f);

    want = 6'b010100;
    step(2);
    chk(bus_en == 6'b000100, "R3 fixed winner", 32'(bus_en), 32'h04);

    rot = 1'b1; want = 6'b010010;
    step(2);
    chk(bus_en == 6'b010000, "R4 rotating winner", 32'(bus_en), 32'h10);

    rot = 1'b0; want = 6'b100010;
    step(2);
    chk(bus_en == 6'b000010, "R10 mode switch", 32'(bus_en), 32'h02);

    want = 6'b000011;
    step(6);
    chk(bus_en == 6'b000010, "R5 owner keeps bus", 32'(bus_en), 32'h02);

    busy[1] = 1'b1; host_req_n = 1'b0;
    step(3);
    chk(bus_en == 6'b000010 && hbg_line, "R7 busy holds", 32'(bus_en), 32'h02);
    busy[1] = 1'b0;
    step(1);
    chk(bus_en == '0 && hbg_line, "R7 release cycle", {hbg_line, bus_en}, 7'h40);
    step(1);
    chk(!hbg_line && bus_en == '0, "R7 grant", {hbg_line, bus_en}, 7'h00);

    want = 6'b000101;
    step(4);
    chk(!hbg_line && is_m == 6'b000010, "R8 grant held frozen", {hbg_line, is_m}, 7'h02);
    host_req_n = 1'b1;
    step(1);
    chk(hbg_line && bus_en == 6'b000010, "R8 resume", {hbg_line, bus_en}, 7'h42);
    step(1);
    chk(bus_en == 6'b000001, "R8 arbitration resumes", 32'(bus_en), 32'h01);

    want = 6'b001101; dma = 6'b000101; core = 6'b001000;
    step(1);
    chk(!cpa_line, "R9 cpa driven", 32'(cpa_line), 0);
    step(2);
    chk(bus_en == 6'b001000, "R9 core wins", 32'(bus_en), 32'h08);
    core = '0; dma = '0;

    for (int it = 0; it < 3000; it++) begin
      want = N'($urandom);
      busy = N'($urandom) & N'($urandom);
      dma  = N'($urandom);
      core = (($urandom % 8) == 0) ? N'(1 << ($urandom % N)) : '0;
      if (($urandom % 64) == 0) rot = ~rot;
      if ((it % 150) == 75) begin
        busy = '0;
        host_req_n = 1'b0;
        for (int t = 0; t < 20 && hbg_line; t++) step(1);
        chk(!hbg_line && bus_en == '0, "R7 random grant", {hbg_line, bus_en}, 7'h00);
        step(3);
        host_req_n = 1'b1;
      end
      step(1);
    end

    finish_run();
  end
endmodule